// File: doc/BRIEF.md
# Masked Packed Absolute-Value Unit

This block is a SIMD execution datapath. It takes a source vector of up to 512 bits and the previous contents of the destination register. It returns a new destination value in which every signed lane of the active vector holds its magnitude. The lane width can be 8, 16, 32 or 64 bits, and the active vector length can be 128, 256 or 512 bits. A per-lane writemask chooses, lane by lane, between the computed magnitude and a fallback value. The fallback is either the old destination lane (merging) or zero (zeroing). For 32- and 64-bit lanes, a memory-sourced operand can be broadcast from lane 0 to every lane.

Two encoding flavours are supported. In the new flavour, bits above the active length are cleared. A 4-bit reserved specifier must also read all ones; any other value flags an illegal operation, and the destination is not written. The legacy flavour works on 128 bits only, leaves the upper destination bits as they were, and has no masking and no broadcast.

Each operation is accepted on `op_valid` and is registered once. A three-state output sequencer reports it one cycle later. The states are:
- ST_IDLE: no result this cycle.
- ST_DONE: a legal operation finished.
- ST_FAULT: an illegal operation was flagged.

From any state, the sequencer moves to ST_DONE on a legal accepted operation, to ST_FAULT on an illegal one, and back to ST_IDLE when `op_valid` is low.

Top module: `pabs_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released with no operation, `res_valid` and `res_illegal` are 0 and `res_vec` is all zeros.
- R2: An operation presented with `op_valid`=1 at a rising edge is reported with `res_valid`=1 after that edge. With `op_valid`=0, `res_valid` falls after the next edge and `res_vec` keeps its value.
- R3: `lane_sz` selects the lane width: 0=8, 1=16, 2=32, 3=64 bits. Each selected lane is written with the two's-complement magnitude of its signed source lane. The most negative value (for example 0x80 in a byte lane) comes out with its bit pattern unchanged.
- R4: `vlen` selects the active length: 0=128, 1=256, 2=512 bits, and code 3 is treated as 512. The number of active lanes is that length divided by the lane width.
- R5: When `mask_en`=0, or when mask bit j is 1, active lane j receives the magnitude of its source lane.
- R6: When `mask_en`=1, `zero_mode`=0 and mask bit j is 0, active lane j keeps the corresponding lane of `prev_vec`.
- R7: When `mask_en`=1, `zero_mode`=1 and mask bit j is 0, active lane j is written as zero.
- R8: Mask bits at or above the active lane count have no effect on the result.
- R9: When `bcast`=1 and `src_mem`=1 with 32- or 64-bit lanes, every active lane uses source lane 0. With 8- or 16-bit lanes, or with `src_mem`=0, `bcast` is ignored.
- R10: With `new_enc`=1, result bits from the active length up to bit 511 are zero.
- R11: With `new_enc`=0, the active length is 128 bits whatever `vlen` says. Bits 511:128 keep `prev_vec`. `mask_en` and `bcast` are ignored, and `spec_field` is not checked.
- R12: With `new_enc`=1 and `spec_field` not 4'b1111, an accepted operation sets `res_illegal`=1 together with `res_valid`, and `res_vec` keeps its previous value. A legal operation reports `res_illegal`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| lane_sz | input | 2 | Lane width code |
| vlen | input | 2 | Active vector length code |
| new_enc | input | 1 | 1 = new encoding, 0 = legacy 128-bit |
| mask_en | input | 1 | Writemask in use |
| zero_mode | input | 1 | 1 = zeroing, 0 = merging for masked-off lanes |
| bcast | input | 1 | Broadcast request |
| src_mem | input | 1 | Source operand came from memory |
| spec_field | input | 4 | Reserved operand specifier |
| wmask | input | 64 | Per-lane writemask, bit j for lane j |
| src_vec | input | 512 | Source vector |
| prev_vec | input | 512 | Previous destination value |
| res_valid | output | 1 | Result valid |
| res_illegal | output | 1 | Illegal-operation flag |
| res_vec | output | 512 | Registered destination value |

## Verification
The embedded assertions check several properties on every cycle:
- the one-cycle valid latency;
- that the result is held on an illegal operation;
- that the upper bits are cleared in the new encoding and kept in legacy mode;
- the treatment of masked-off lane 0 in both merging and zeroing mode.

Only the bench's sweeps can show the magnitudes themselves, because the expected values are computed arithmetically in the bench. This covers the most-negative corner, lane counts per width and length, ignored high mask bits, and the broadcast that applies only to wide lanes from memory.

// File: rtl/pabs_pkg.sv
package pabs_pkg;
    typedef enum logic [1:0] {
        LS_B8  = 2'd0,
        LS_B16 = 2'd1,
        LS_B32 = 2'd2,
        LS_B64 = 2'd3
    } lane_sz_e;

    typedef enum logic [1:0] {
        VL_Q   = 2'd0,
        VL_H   = 2'd1,
        VL_F   = 2'd2,
        VL_RSV = 2'd3
    } vlen_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2
    } out_state_e;

    localparam logic [3:0] SPEC_LEGAL = 4'b1111;
    localparam int         NUM_SIZES  = 4;
    localparam int         MIN_LANE   = 8;
endpackage

// File: rtl/pabs_abs_slice.sv
module pabs_abs_slice #(
    parameter int VW      = 512,
    parameter int LW      = 8,
    parameter bit BCST_OK = 1'b0
) (
    input  logic [VW-1:0] src,
    input  logic          bcst,
    output logic [VW-1:0] mag
);
    localparam int NL = VW / LW;

    logic use_b;
    assign use_b = BCST_OK ? bcst : 1'b0;

    for (genvar j = 0; j < NL; j++) begin : g_lane
        logic [LW-1:0] lin;
        assign lin = use_b ? src[LW-1:0] : src[j*LW +: LW];
        assign mag[j*LW +: LW] = lin[LW-1] ? (~lin + 1'b1) : lin;
    end
endmodule

// File: rtl/pabs_lane_ctl.sv
module pabs_lane_ctl import pabs_pkg::*; #(
    parameter int VW = 512
) (
    input  logic [1:0]        lane_sz,
    input  logic [1:0]        vl_eff,
    input  logic              mask_on,
    input  logic              zero_mode,
    input  logic              new_enc,
    input  logic [VW/8-1:0]   wmask,
    output logic [VW-1:0]     take,
    output logic [VW-1:0]     hold
);
    localparam int VL_Q_W = VW / 4;
    localparam int VL_H_W = VW / 2;

    logic [VW-1:0] sel;
    logic [VW-1:0] in_range;

    for (genvar b = 0; b < VW; b++) begin : g_bit
        logic [NUM_SIZES-1:0] mb;
        assign mb = {wmask[b/(MIN_LANE*8)], wmask[b/(MIN_LANE*4)],
                     wmask[b/(MIN_LANE*2)], wmask[b/MIN_LANE]};
        assign sel[b] = mb[lane_sz];
        if (b < VL_Q_W) begin : g_q
            assign in_range[b] = 1'b1;
        end else if (b < VL_H_W) begin : g_h
            assign in_range[b] = (vl_eff != VL_Q);
        end else begin : g_f
            assign in_range[b] = (vl_eff == VL_F);
        end
    end

    always_comb begin
        take = in_range & (~{VW{mask_on}} | sel);
        hold = ~take & ((~in_range & {VW{~new_enc}}) |
                        (in_range & {VW{~zero_mode}}));
    end
endmodule

// File: rtl/pabs_unit.sv
module pabs_unit import pabs_pkg::*; #(
    parameter int VW = 512
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [1:0]      lane_sz,
    input  logic [1:0]      vlen,
    input  logic            new_enc,
    input  logic            mask_en,
    input  logic            zero_mode,
    input  logic            bcast,
    input  logic            src_mem,
    input  logic [3:0]      spec_field,
    input  logic [VW/8-1:0] wmask,
    input  logic [VW-1:0]   src_vec,
    input  logic [VW-1:0]   prev_vec,
    output logic            res_valid,
    output logic            res_illegal,
    output logic [VW-1:0]   res_vec
);
    localparam int LEG_W = VW / 4;

    logic [1:0]    vl_eff;
    logic          mask_on, bc_on, illegal;
    logic [VW-1:0] mag_s [NUM_SIZES];
    logic [VW-1:0] mag, take, hold, nxt;
    out_state_e    state_q, state_d;

    always_comb begin
        if (!new_enc)               vl_eff = VL_Q;
        else if (vlen == VL_RSV)    vl_eff = VL_F;
        else                        vl_eff = vlen;
        mask_on = new_enc & mask_en;
        bc_on   = new_enc & bcast & src_mem;
        illegal = new_enc & (spec_field != SPEC_LEGAL);
    end

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        pabs_abs_slice #(
            .VW(VW), .LW(MIN_LANE << s), .BCST_OK(s >= 2)
        ) u_slice (
            .src(src_vec), .bcst(bc_on), .mag(mag_s[s])
        );
    end

    assign mag = mag_s[lane_sz];

    pabs_lane_ctl #(.VW(VW)) u_ctl (
        .lane_sz(lane_sz), .vl_eff(vl_eff), .mask_on(mask_on),
        .zero_mode(zero_mode), .new_enc(new_enc), .wmask(wmask),
        .take(take), .hold(hold)
    );

    assign nxt = (mag & take) | (prev_vec & hold);

    // next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAULT: begin
                if (op_valid) state_d = illegal ? ST_FAULT : ST_DONE;
                else          state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)                   res_vec <= '0;
        else if (op_valid && !illegal) res_vec <= nxt;
    end

    assign res_valid   = (state_q != ST_IDLE);
    assign res_illegal = (state_q == ST_FAULT);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !res_illegal && res_vec == '0));

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    p_idle_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && $stable(res_vec)));

    p_merge_lane0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && new_enc && spec_field == SPEC_LEGAL && mask_en &&
         !zero_mode && !wmask[0])
        |=> res_vec[7:0] == $past(prev_vec[7:0]));

    p_zero_lane0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && new_enc && spec_field == SPEC_LEGAL && mask_en &&
         zero_mode && !wmask[0])
        |=> res_vec[7:0] == 8'h00);

    p_upper_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && new_enc && spec_field == SPEC_LEGAL && vlen == VL_Q)
        |=> res_vec[VW-1:LEG_W] == '0);

    p_legacy_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !new_enc)
        |=> res_vec[VW-1:LEG_W] == $past(prev_vec[VW-1:LEG_W]));

    p_illegal_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && new_enc && spec_field != SPEC_LEGAL)
        |=> (res_illegal && res_valid && $stable(res_vec)));
endmodule

// File: tb/pabs_unit_test.sv
module pabs_unit_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [1:0]   lane_sz = '0, vlen = '0;
    logic         new_enc = 1'b1, mask_en = 1'b0, zero_mode = 1'b0;
    logic         bcast = 1'b0, src_mem = 1'b0;
    logic [3:0]   spec_field = 4'hF;
    logic [63:0]  wmask = '0;
    logic [511:0] src_vec = '0, prev_vec = '0;
    logic         res_valid, res_illegal;
    logic [511:0] res_vec;

    int nchk = 0, nbad = 0;
    logic [511:0] exp_q = '0;
    logic [63:0]  rs = 64'h9E3779B97F4A7C15;

    always #2 clk = ~clk;

    pabs_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .lane_sz(lane_sz),
        .vlen(vlen), .new_enc(new_enc), .mask_en(mask_en),
        .zero_mode(zero_mode), .bcast(bcast), .src_mem(src_mem),
        .spec_field(spec_field), .wmask(wmask), .src_vec(src_vec),
        .prev_vec(prev_vec), .res_valid(res_valid),
        .res_illegal(res_illegal), .res_vec(res_vec)
    );

    function automatic logic [63:0] rnd64();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 7);
        rs = rs ^ (rs << 17);
        return rs;
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] v = '0;
        for (int k = 0; k < 8; k++) v = (v << 64) | {448'b0, rnd64()};
        return v;
    endfunction

    function automatic logic [511:0] model(
        input int ls, input int vl, input bit ne, input bit me, input bit zm,
        input bit bc, input bit mem, input logic [63:0] m,
        input logic [511:0] s, input logic [511:0] p);
        int lw = 8 << ls;
        int vlb = !ne ? 128 : (vl == 0 ? 128 : (vl == 1 ? 256 : 512));
        bit mo = ne && me;
        bit bo = ne && bc && mem && ls >= 2;
        logic [63:0] lm = (64'h1 << lw) - 64'h1;
        logic [511:0] r = '0;
        for (int j = 0; j < 512 / lw; j++) begin
            logic [63:0] v, a, pv, o;
            v  = (bo ? s[63:0] : s[j*lw +: 64 < 512 ? 64 : 64] ) & lm;
            v  = bo ? (s[63:0] & lm) : ((s >> (j*lw)) & {448'b0, lm});
            a  = v[lw-1] ? ((~v + 64'h1) & lm) : v;
            pv = 64'((p >> (j*lw))) & lm;
            if (j*lw >= vlb)        o = ne ? 64'h0 : pv;
            else if (!mo || m[j])   o = a;
            else                    o = zm ? 64'h0 : pv;
            r = r | ({448'b0, o} << (j*lw));
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [511:0] act,
                       input logic [511:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic apply(input string req, input int ls, input int vl,
                         input bit ne, input bit me, input bit zm,
                         input bit bc, input bit mem, input logic [3:0] sp,
                         input logic [63:0] m, input logic [511:0] s,
                         input logic [511:0] p);
        bit ill = ne && (sp != 4'hF);
        @(negedge clk);
        op_valid = 1'b1; lane_sz = 2'(ls); vlen = 2'(vl); new_enc = ne;
        mask_en = me; zero_mode = zm; bcast = bc; src_mem = mem;
        spec_field = sp; wmask = m; src_vec = s; prev_vec = p;
        if (!ill) exp_q = model(ls, vl, ne, me, zm, bc, mem, m, s, p);
        @(negedge clk);
        op_valid = 1'b0;
        chk({req, " valid"}, {511'b0, res_valid}, 512'd1);
        chk({req, " illegal"}, {511'b0, res_illegal}, {511'b0, ill});
        chk({req, " data"}, res_vec, exp_q);
    endtask

    initial begin
        #(4 * 150000);
        nbad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 valid", {511'b0, res_valid}, '0);
        chk("R1 illegal", {511'b0, res_illegal}, '0);
        chk("R1 data", res_vec, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", {510'b0, res_valid, res_illegal}, '0);

        // R3/R4/R5/R6/R7/R9/R10 sweep
        for (int ls = 0; ls < 4; ls++)
            for (int vl = 0; vl < 4; vl++)
                for (int md = 0; md < 3; md++)
                    for (int bm = 0; bm < 4; bm++)
                        for (int rep = 0; rep < 2; rep++)
                            apply("R3-sweep", ls, vl, 1'b1, md != 0, md == 2,
                                  bm[0], bm[1], 4'hF, rnd64(), rnd512(),
                                  rnd512());

        // R3: most negative lane values keep their bit pattern
        apply("R3 min8", 0, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, '0,
              {64{8'h80}}, '0);
        chk("R3 min8 pattern", res_vec, {64{8'h80}});
        apply("R3 min64", 3, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, '0,
              {8{64'h8000_0000_0000_0000}}, '0);
        chk("R3 min64 pattern", res_vec, {8{64'h8000_0000_0000_0000}});

        // R8: mask bits above lane count ignored (16 byte lanes, merging)
        apply("R8 highmask", 0, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF,
              64'hFFFF_FFFF_FFFF_0000, {64{8'hFF}}, {64{8'h5A}});
        chk("R8 low kept", {384'b0, res_vec[127:0]}, {384'b0, {16{8'h5A}}});

        // R9: broadcast on 32-bit lanes from memory
        apply("R9 bcast32", 2, 2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, '0,
              {{480{1'b1}}, 32'hFFFF_FFF9}, '0);
        chk("R9 bcast32 value", res_vec, {16{32'd7}});

        // R11: legacy sweep, vlen and mask/broadcast ignored
        for (int ls = 0; ls < 4; ls++)
            for (int vl = 0; vl < 4; vl++)
                apply("R11 legacy", ls, vl, 1'b0, 1'b1, vl[0], 1'b1, 1'b1,
                      4'(vl * 3), rnd64(), rnd512(), rnd512());

        // R12: illegal specifier holds result
        apply("R12 legal", 1, 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, '0,
              rnd512(), rnd512());
        apply("R12 illegal", 1, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h7, '0,
              rnd512(), rnd512());
        apply("R12 illegal0", 3, 2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, '0,
              rnd512(), rnd512());

        // R2: no operation -> valid drops, data held
        @(negedge clk);
        src_vec = rnd512(); prev_vec = rnd512();
        @(negedge clk);
        chk("R2 valid drop", {511'b0, res_valid}, '0);
        chk("R2 hold", res_vec, exp_q);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule